// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Capture-Only Chain

This block is the serial test port of a device. A four-wire serial master (test clock, mode select, data in, data out) walks the standard sixteen-state controller and can read a fixed identification word, pass data straight through a one-bit bypass stage, or take a snapshot of the device pin states and shift it out. The boundary chain only captures and shifts. It never drives a pin from scanned data, and the Update-DR state changes nothing.

Two of the boundary instructions also raise a control line. That line tells the functional output drivers of the device to go to high impedance while the instruction is active. The serial output is launched on the falling edge of the test clock, and it comes with its own output enable. The enable is high only while a register is being shifted.

Top module: `tap_scan_port`

## Requirements
- R1: The controller follows the standard sixteen-state test-port state graph and samples `tms` and `tdi` on the rising edge of `tck`. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state.
- R2: While `por_n` is low, the controller is in Test-Logic-Reset, the active instruction is 001, `tdo_oe` is 0 and `outputs_hiz` is 0.
- R3: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is 1 only when the controller is in Shift-IR or Shift-DR at that falling edge.
- R4: The instruction shift register is 3 bits wide. Capture-IR loads it with 3'b001, so the first three bits shifted out are 1, 0, 0.
- R5: A newly shifted instruction becomes active only in Update-IR. Entering Test-Logic-Reset makes 001 active again.
- R6: Instruction 001 selects a 32-bit identification register that captures {REV[3:0], DEPTH[4:0], WIDTH[4:0], DEV[5:0], 11'b00000110100, 1'b1}. Bit 0 is 1, and bits 11:1 hold the vendor code.
- R7: Instruction 111 and the unassigned codes 011, 101 and 110 select a 1-bit bypass register, which captures 0 in Capture-DR.
- R8: Instructions 000, 010 and 100 select a 51-bit boundary register. In Capture-DR, bit i of this register loads `pin_snap[i]`.
- R9: `outputs_hiz` is 1 exactly while the active instruction is 000 or 010, and 0 for every other instruction.
- R10: In Shift-DR and Shift-IR, `tdi` enters at the most significant bit of the selected register and its least significant bit appears on `tdo`. Passing through Pause-DR keeps the partly shifted contents.
- R11: Update-DR has no effect: it leaves the active instruction, `outputs_hiz` and the contents of the data registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| pin_snap | input | 51 | Parallel state of the device pins, captured by the boundary instructions |
| tdo | output | 1 | Serial data out, launched on the falling edge |
| tdo_oe | output | 1 | Output enable for `tdo` |
| outputs_hiz | output | 1 | Forces the functional outputs of the device to high impedance |

## Verification
On a single rising edge, an instruction update can both change `outputs_hiz` and change which chain the next Shift-DR reads. Five consecutive high `tms` edges can also cut a shift short and restore the identification instruction. The bench provokes the first case by loading EXTEST and SAMPLE Z from other instructions. It checks `outputs_hiz` in Exit1-IR, before the update, and again after the update, then confirms that the next scan returns the boundary snapshot. For the second case, it abandons a bypass-mode Shift-DR with five high `tms` edges and judges the result by the identification word returned on the following scan.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;

    typedef enum logic [3:0] {
        TS_RESET  = 4'd0,
        TS_IDLE   = 4'd1,
        TS_SEL_DR = 4'd2,
        TS_CAP_DR = 4'd3,
        TS_SHF_DR = 4'd4,
        TS_EX1_DR = 4'd5,
        TS_PAU_DR = 4'd6,
        TS_EX2_DR = 4'd7,
        TS_UPD_DR = 4'd8,
        TS_SEL_IR = 4'd9,
        TS_CAP_IR = 4'd10,
        TS_SHF_IR = 4'd11,
        TS_EX1_IR = 4'd12,
        TS_PAU_IR = 4'd13,
        TS_EX2_IR = 4'd14,
        TS_UPD_IR = 4'd15
    } tap_state_e;

    localparam int IR_W = 3;
    localparam int ID_W = 32;
    typedef logic [IR_W-1:0] ir_t;

    localparam ir_t OP_EXT = 3'b000;
    localparam ir_t OP_IDC = 3'b001;
    localparam ir_t OP_SMZ = 3'b010;
    localparam ir_t OP_SMP = 3'b100;
    localparam ir_t OP_BYP = 3'b111;
    localparam ir_t IR_CAPTURE = 3'b001;

    typedef enum logic [1:0] {
        CH_BYPASS = 2'd0,
        CH_IDENT  = 2'd1,
        CH_BOUND  = 2'd2
    } chain_e;

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state_o
);

    typedef struct packed {
        tap_state_e st;
    } fsm_regs_t;

    fsm_regs_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            TS_RESET:  fsm_d.st = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   fsm_d.st = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: fsm_d.st = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: fsm_d.st = tms ? TS_EX1_DR : TS_SHF_DR;
            TS_SHF_DR: fsm_d.st = tms ? TS_EX1_DR : TS_SHF_DR;
            TS_EX1_DR: fsm_d.st = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: fsm_d.st = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: fsm_d.st = tms ? TS_UPD_DR : TS_SHF_DR;
            TS_UPD_DR: fsm_d.st = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: fsm_d.st = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: fsm_d.st = tms ? TS_EX1_IR : TS_SHF_IR;
            TS_SHF_IR: fsm_d.st = tms ? TS_EX1_IR : TS_SHF_IR;
            TS_EX1_IR: fsm_d.st = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: fsm_d.st = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: fsm_d.st = tms ? TS_UPD_IR : TS_SHF_IR;
            TS_UPD_IR: fsm_d.st = tms ? TS_SEL_DR : TS_IDLE;
            default:   fsm_d.st = TS_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) fsm_q <= '{st: TS_RESET};
        else        fsm_q <= fsm_d;
    end

    assign state_o = fsm_q.st;

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tdi,
    input  tap_state_e state_i,
    output ir_t        ir_act_o,
    output logic       ir_lsb_o,
    output chain_e     chain_o,
    output logic       hiz_o
);

    typedef struct packed {
        ir_t shf;
        ir_t act;
    } ir_regs_t;

    ir_regs_t ir_d, ir_q;

    always_comb begin
        ir_d = ir_q;
        case (state_i)
            TS_RESET:  ir_d.act = OP_IDC;
            TS_CAP_IR: ir_d.shf = IR_CAPTURE;
            TS_SHF_IR: ir_d.shf = {tdi, ir_q.shf[IR_W-1:1]};
            TS_UPD_IR: ir_d.act = ir_q.shf;
            default:   ;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) ir_q <= '{shf: IR_CAPTURE, act: OP_IDC};
        else        ir_q <= ir_d;
    end

    // Decode of the active instruction; unassigned codes fall to bypass.
    always_comb begin
        chain_o = CH_BYPASS;
        hiz_o   = 1'b0;
        case (ir_q.act)
            OP_EXT, OP_SMZ: begin
                chain_o = CH_BOUND;
                hiz_o   = 1'b1;
            end
            OP_SMP:  chain_o = CH_BOUND;
            OP_IDC:  chain_o = CH_IDENT;
            default: chain_o = CH_BYPASS;
        endcase
    end

    assign ir_act_o = ir_q.act;
    assign ir_lsb_o = ir_q.shf[0];

endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
    import tap_pkg::*;
#(
    parameter int          BSR_W    = 51,
    parameter logic [3:0]  ID_REV   = 4'h1,
    parameter logic [4:0]  ID_DEPTH = 5'h0A,
    parameter logic [4:0]  ID_WIDTH = 5'h03,
    parameter logic [5:0]  ID_DEV   = 6'h00
) (
    input  logic             tck,
    input  logic             por_n,
    input  logic             tdi,
    input  tap_state_e       state_i,
    input  chain_e           chain_i,
    input  logic [BSR_W-1:0] pin_snap_i,
    output logic             dr_lsb_o
);

    localparam logic [10:0]     VENDOR  = 11'b00000110100;
    localparam logic [ID_W-1:0] ID_WORD = {ID_REV, ID_DEPTH, ID_WIDTH, ID_DEV, VENDOR, 1'b1};

    typedef struct packed {
        logic             byp;
        logic [ID_W-1:0]  idr;
        logic [BSR_W-1:0] bsr;
    } dr_regs_t;

    dr_regs_t dr_d, dr_q;

    always_comb begin
        dr_d = dr_q;
        if (state_i == TS_CAP_DR) begin
            case (chain_i)
                CH_IDENT: dr_d.idr = ID_WORD;
                CH_BOUND: dr_d.bsr = pin_snap_i;
                default:  dr_d.byp = 1'b0;
            endcase
        end else if (state_i == TS_SHF_DR) begin
            case (chain_i)
                CH_IDENT: dr_d.idr = {tdi, dr_q.idr[ID_W-1:1]};
                CH_BOUND: dr_d.bsr = {tdi, dr_q.bsr[BSR_W-1:1]};
                default:  dr_d.byp = tdi;
            endcase
        end
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) dr_q <= '{byp: 1'b0, idr: ID_WORD, bsr: '0};
        else        dr_q <= dr_d;
    end

    always_comb begin
        case (chain_i)
            CH_IDENT: dr_lsb_o = dr_q.idr[0];
            CH_BOUND: dr_lsb_o = dr_q.bsr[0];
            default:  dr_lsb_o = dr_q.byp;
        endcase
    end

endmodule

// File: rtl/tap_scan_port.sv
`timescale 1ns/1ps
module tap_scan_port
    import tap_pkg::*;
#(
    parameter int          BSR_W    = 51,
    parameter logic [3:0]  ID_REV   = 4'h1,
    parameter logic [4:0]  ID_DEPTH = 5'h0A,
    parameter logic [4:0]  ID_WIDTH = 5'h03,
    parameter logic [5:0]  ID_DEV   = 6'h00
) (
    input  logic             tck,
    input  logic             por_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic [BSR_W-1:0] pin_snap,
    output logic             tdo,
    output logic             tdo_oe,
    output logic             outputs_hiz
);

    tap_state_e st;
    ir_t        ir_act;
    logic       ir_lsb;
    logic       dr_lsb;
    chain_e     chain;

    tap_fsm u_fsm (
        .tck     (tck),
        .por_n   (por_n),
        .tms     (tms),
        .state_o (st)
    );

    tap_ir u_ir (
        .tck      (tck),
        .por_n    (por_n),
        .tdi      (tdi),
        .state_i  (st),
        .ir_act_o (ir_act),
        .ir_lsb_o (ir_lsb),
        .chain_o  (chain),
        .hiz_o    (outputs_hiz)
    );

    tap_dr #(
        .BSR_W    (BSR_W),
        .ID_REV   (ID_REV),
        .ID_DEPTH (ID_DEPTH),
        .ID_WIDTH (ID_WIDTH),
        .ID_DEV   (ID_DEV)
    ) u_dr (
        .tck        (tck),
        .por_n      (por_n),
        .tdi        (tdi),
        .state_i    (st),
        .chain_i    (chain),
        .pin_snap_i (pin_snap),
        .dr_lsb_o   (dr_lsb)
    );

    // Falling-edge launch stage for the serial output and its enable.
    typedef struct packed {
        logic dat;
        logic oe;
    } out_regs_t;

    out_regs_t out_d, out_q;

    always_comb begin
        out_d = '0;
        if (st == TS_SHF_IR)      out_d = '{dat: ir_lsb, oe: 1'b1};
        else if (st == TS_SHF_DR) out_d = '{dat: dr_lsb, oe: 1'b1};
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign tdo    = out_q.dat;
    assign tdo_oe = out_q.oe;

endmodule

// File: rtl/tap_scan_port_chk.sv
`timescale 1ns/1ps
module tap_scan_port_chk
    import tap_pkg::*;
(
    input logic       tck,
    input logic       por_n,
    input logic       tms,
    input tap_state_e state,
    input ir_t        ir_act,
    input logic       tdo_oe,
    input logic       outputs_hiz
);

    logic [2:0] hi_run;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)          hi_run <= 3'd0;
        else if (!tms)       hi_run <= 3'd0;
        else if (hi_run < 5) hi_run <= hi_run + 3'd1;
    end

    AST_FIVE_HIGH_RESET: assert property (@(posedge tck) disable iff (!por_n)
        (hi_run == 3'd5) |-> (state == TS_RESET)); // R1

    AST_OE_ONLY_SHIFT: assert property (@(posedge tck) disable iff (!por_n)
        tdo_oe |-> (state == TS_SHF_DR || state == TS_SHF_IR)); // R3

    AST_RESET_LOADS_IDCODE: assert property (@(posedge tck) disable iff (!por_n)
        (state == TS_RESET) |=> (ir_act == OP_IDC)); // R5

    AST_HIZ_MOVES_AT_UPDATE: assert property (@(posedge tck) disable iff (!por_n)
        !$stable(outputs_hiz) |-> ($past(state) == TS_UPD_IR || $past(state) == TS_RESET)); // R9

    AST_UPDR_KEEPS_IR: assert property (@(posedge tck) disable iff (!por_n)
        (state == TS_UPD_DR) |=> ($stable(ir_act) && $stable(outputs_hiz))); // R11

endmodule

bind tap_scan_port tap_scan_port_chk chk_i (
    .tck         (tck),
    .por_n       (por_n),
    .tms         (tms),
    .state       (st),
    .ir_act      (ir_act),
    .tdo_oe      (tdo_oe),
    .outputs_hiz (outputs_hiz)
);

// File: tb/tap_scan_port_tb_top.sv
`timescale 1ns/1ps
module tap_scan_port_tb_top;

    localparam int BW = 51;
    localparam logic [31:0] EXP_ID = {4'h1, 5'h0A, 5'h03, 6'h00, 11'b00000110100, 1'b1};

    logic          tck = 1'b0;
    logic          por_n = 1'b0;
    logic          tms = 1'b1;
    logic          tdi = 1'b0;
    logic [BW-1:0] pin_snap = 51'h2A5C31E7B9D26;
    logic          tdo, tdo_oe, outputs_hiz;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    typedef struct {
        logic  v;
        string req;
    } exp_t;
    exp_t exp_q[$];
    logic expect_now = 1'b0;

    tap_scan_port dut_i (
        .tck         (tck),
        .por_n       (por_n),
        .tms         (tms),
        .tdi         (tdi),
        .pin_snap    (pin_snap),
        .tdo         (tdo),
        .tdo_oe      (tdo_oe),
        .outputs_hiz (outputs_hiz)
    );

    always #10 tck = ~tck;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops one expected serial bit per flagged cycle.
    initial begin
        forever begin
            @(negedge tck);
            #5;
            if (expect_now) begin
                exp_t it;
                if (exp_q.size() == 0) begin
                    chk(0, "R10", "scoreboard empty", 0, 0);
                end else begin
                    it = exp_q.pop_front();
                    chk(tdo_oe === 1'b1 && tdo === it.v, it.req, "serial bit",
                        {62'd0, tdo_oe, tdo}, {62'd0, 1'b1, it.v});
                end
            end
        end
    end

    // Driver: one tck cycle, optionally pushing the tdo bit expected in it.
    task automatic step(input logic m, input logic d, input bit has_exp,
                        input logic ev, input string req);
        @(negedge tck);
        #2;
        tms = m;
        tdi = d;
        if (has_exp) exp_q.push_back('{v: ev, req: req});
        expect_now = has_exp;
        @(posedge tck);
        #1;
        expect_now = 1'b0;
    endtask

    task automatic load_ir(input logic [2:0] code, output logic hiz_before);
        step(1, 0, 0, 0, "");
        step(1, 0, 0, 0, "");
        step(0, 0, 0, 0, "");
        step(0, 0, 0, 0, "");
        for (int i = 0; i < 3; i++) begin
            // R4: capture pattern 3'b001 shifted out LSB first
            step(i == 2, code[i], 1, (i == 0), "R4");
        end
        hiz_before = outputs_hiz;
        step(1, 0, 0, 0, "");
        step(0, 0, 0, 0, "");
    endtask

    task automatic scan_dr(input int n, input logic [127:0] din,
                           input logic [127:0] ev, input string req, input int pause_at);
        step(1, 0, 0, 0, "");
        step(0, 0, 0, 0, "");
        step(0, 0, 0, 0, "");
        for (int i = 0; i < n; i++) begin
            if (i == pause_at) begin
                step(1, din[i], 1, ev[i], req);
                step(0, 0, 0, 0, "");
                @(negedge tck);
                #3;
                chk(tdo_oe == 1'b0, "R3", "oe in Pause-DR", {63'd0, tdo_oe}, 0);
                step(1, 0, 0, 0, "");
                step(0, 0, 0, 0, "");
            end else begin
                step(i == n - 1, din[i], 1, ev[i], req);
            end
        end
        step(1, 0, 0, 0, "");
        step(0, 0, 0, 0, "");
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic hb;
        logic [127:0] din, ev;

        // R2: reset state
        #35;
        chk(tdo_oe == 1'b0, "R2", "oe in reset", {63'd0, tdo_oe}, 0);
        chk(outputs_hiz == 1'b0, "R2", "hiz in reset", {63'd0, outputs_hiz}, 0);
        @(negedge tck);
        por_n = 1'b1;
        step(0, 0, 0, 0, "");

        // R6: default instruction reads the identification word
        scan_dr(32, '0, {96'd0, EXP_ID}, "R6", -1);

        // R3: enable rises at the falling edge after entering Shift-DR
        step(1, 0, 0, 0, "");
        step(0, 0, 0, 0, "");
        step(0, 0, 0, 0, "");
        #2;
        chk(tdo_oe == 1'b0, "R3", "oe before falling edge", {63'd0, tdo_oe}, 0);
        @(negedge tck);
        #2;
        chk(tdo_oe == 1'b1 && tdo == EXP_ID[0], "R3", "oe/tdo after falling edge",
            {62'd0, tdo_oe, tdo}, {62'd0, 1'b1, EXP_ID[0]});
        step(1, 0, 0, 0, "");
        step(1, 0, 0, 0, "");
        step(0, 0, 0, 0, "");
        #2;
        chk(tdo_oe == 1'b0, "R3", "oe in Run-Test/Idle", {63'd0, tdo_oe}, 0);

        // R7: bypass with 1-bit delay and captured 0
        load_ir(3'b111, hb);
        din = 128'h0;
        din[9:0] = 10'b1011001101;
        ev = {din[126:0], 1'b0};
        scan_dr(10, din, ev, "R7", -1);

        // R7: unassigned code behaves as bypass
        load_ir(3'b101, hb);
        din[9:0] = 10'b0110100111;
        ev = {din[126:0], 1'b0};
        scan_dr(10, din, ev, "R7", -1);

        // R1: five high tms edges abandon a shift and restore IDCODE (R5)
        load_ir(3'b011, hb);
        step(1, 0, 0, 0, "");
        step(0, 0, 0, 0, "");
        step(0, 0, 0, 0, "");
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "");
        step(0, 0, 0, 0, "");
        scan_dr(32, '0, {96'd0, EXP_ID}, "R1", -1);

        // R8/R9: SAMPLE/PRELOAD captures pins without forcing high impedance
        load_ir(3'b100, hb);
        chk(outputs_hiz == 1'b0, "R9", "hiz for 100", {63'd0, outputs_hiz}, 0);
        ev = '0;
        ev[BW-1:0] = pin_snap;
        scan_dr(BW, '0, ev, "R8", -1);

        // R5/R9: EXTEST takes effect only at Update-IR
        load_ir(3'b000, hb);
        chk(hb == 1'b0, "R5", "hiz before Update-IR", {63'd0, hb}, 0);
        chk(outputs_hiz == 1'b1, "R9", "hiz for 000", {63'd0, outputs_hiz}, 1);

        // R10: tdi enters at MSB, appears after BW shifts; Pause keeps contents
        din = '0;
        din[7:0] = 8'hB4;
        ev = '0;
        ev[BW-1:0] = pin_snap;
        ev[BW+7:BW] = 8'hB4;
        scan_dr(BW + 8, din, ev, "R10", 20);

        // R11: Update-DR changed nothing; instruction still EXTEST
        chk(outputs_hiz == 1'b1, "R11", "hiz after Update-DR", {63'd0, outputs_hiz}, 1);

        // R9/R8: SAMPLE Z forces high impedance and captures a new snapshot
        load_ir(3'b001, hb);
        chk(outputs_hiz == 1'b0, "R9", "hiz for 001", {63'd0, outputs_hiz}, 0);
        load_ir(3'b010, hb);
        chk(hb == 1'b0, "R5", "hiz before Update-IR (010)", {63'd0, hb}, 0);
        chk(outputs_hiz == 1'b1, "R9", "hiz for 010", {63'd0, outputs_hiz}, 1);
        pin_snap = 51'h5_1234_89AB_CDEF;
        ev = '0;
        ev[BW-1:0] = pin_snap;
        din = '0;
        din[BW-1:0] = 51'h7_0F0F_0F0F_0F0F;
        scan_dr(BW, din, ev, "R8", -1);
        chk(outputs_hiz == 1'b1, "R11", "hiz kept after Update-DR", {63'd0, outputs_hiz}, 1);
        scan_dr(BW, '0, ev, "R11", -1);

        // R5: Test-Logic-Reset brings back IDCODE and releases high impedance
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "");
        step(0, 0, 0, 0, "");
        chk(outputs_hiz == 1'b0, "R5", "hiz after reset walk", {63'd0, outputs_hiz}, 0);

        repeat (3) @(posedge tck);
        chk(exp_q.size() == 0, "R10", "scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule